// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Command Engine

This block is the protocol side of a two-wire serial memory device. It takes the raw clock and data lines from the pads, brings them into the system clock domain and finds START and STOP conditions. It then runs the command sequence a master sends: a control byte, an optional two-byte word address, and then write data or read data. It acknowledges the bytes it accepts by pulling the data line low, and it sends read data as an open-drain pull enable.

The word address counter, the page write buffer and the nonvolatile array are outside the block. The engine loads and steps the counter through pulse ports. It hands each write byte to the page buffer with a request that is held until granted, and it fetches each read byte the same way. A STOP that closes a write with accepted data raises a one-cycle program request. While the external program timer reports busy, the engine stays silent even to its own address, so a master can poll with write control bytes until it gets an acknowledge.

Supported commands are byte write, page write, current-address read, random read with a repeated START, and sequential read. A write-protect input lets address bytes through but refuses the data.

Top module: `tw_eeprom_slave`

## Requirements
- R1: A START (data falling while clock high) seen at any point, including in the middle of a byte, abandons the current byte, releases the data line and begins reception of a new control byte. A STOP (data rising while clock high) returns the engine to idle.
- R2: A control byte is bits 7..4 type code 1010, bits 3..1 equal to the strap input, and bit 0 read (1) or write (0). A byte that differs in type code or strap bits gets no acknowledge, and the engine leaves the line released until the next START or STOP.
- R3: After a matching write control byte, the engine acknowledges a high address byte and then a low address byte. Bit 7 of the high byte is dropped. After the low byte it pulses the counter load with the 15-bit address {high[6:0], low}.
- R4: Each write data byte is acknowledged and offered to the page buffer with a request held until granted. Each grant is followed by a counter step flagged as page-confined, so the address wraps within a 64-byte page.
- R5: With write protect high, the control byte and both address bytes are still acknowledged, but the first data byte is refused. No buffer request and no program request follow.
- R6: While busy is high, a matching control byte gets no acknowledge and the data line stays released.
- R7: In a read, each byte is sent MSB first on eight clocks, and the line is released on the ninth. An acknowledge from the master fetches and sends the next sequential byte. A refusal leaves the line released until START or STOP.
- R8: A random read is a write control byte, two address bytes, a repeated START and a read control byte. The first byte returned comes from the loaded address.
- R9: Each fetched read byte steps the counter without page confinement, so a later current-address read continues at the last byte read plus one.
- R10: A STOP after at least one accepted write data byte gives exactly one one-cycle program request. A STOP after only a control byte, or only control and address bytes, gives none.
- R11: After reset the data line is released and no request is raised. The pull enable changes only while the synchronised clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line as seen on the bus |
| sda_pull_o | output | 1 | Pull data line low when 1 |
| strap_i | input | 3 | Device select strap bits |
| wp_i | input | 1 | Write protect |
| busy_i | input | 1 | Program cycle in progress |
| ptr_load_o | output | 1 | Load word address counter (pulse) |
| ptr_load_val_o | output | 15 | Value to load |
| ptr_step_o | output | 1 | Advance word address counter (pulse) |
| ptr_step_page_o | output | 1 | Step wraps within page when 1 |
| wr_req_o | output | 1 | Write byte request to page buffer |
| wr_byte_o | output | 8 | Write byte |
| wr_gnt_i | input | 1 | Page buffer grant |
| rd_req_o | output | 1 | Read byte request |
| rd_gnt_i | input | 1 | Read grant, data valid |
| rd_data_i | input | 8 | Read byte |
| prog_req_o | output | 1 | Start program cycle (pulse) |

## Verification
A bus edge reaches the engine through two synchroniser stages and one edge register, so the pull enable settles three to four system clocks after the master lowers SCL. The bench drives each bit a quarter bit-time (10 clocks) before raising SCL and reads the wired-AND line a further quarter into the high phase, long after that settling. Requests from the engine are answered one clock later by the bench's counter and buffer models. The program request is due a few clocks after STOP, and the bench counts it only after the STOP sequence has finished. A per-clock monitor flags any change of the pull enable while the driven clock has been high for two samples.

// File: rtl/tw_pkg.sv
package tw_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_IGNORE
   } eng_st_t;

   typedef enum logic [1:0] {
      K_CTRL,
      K_AHI,
      K_ALO,
      K_DATA
   } fld_t;

   function automatic fld_t next_fld(input fld_t f);
      case (f)
         K_CTRL:  return K_AHI;
         K_AHI:   return K_ALO;
         default: return K_DATA;
      endcase
   endfunction
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int CW = 2 * STAGES;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tw_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [CW-1:0] chain_q;
   logic [1:0]    prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 2'b11;
      end else begin
         chain_q <= {chain_q[CW-3:0], scl_i, sda_i};
         prev_q  <= chain_q[CW-1:CW-2];
      end
   end

   assign scl_s     = chain_q[CW-1];
   assign sda_s     = chain_q[CW-2];
   assign scl_rise  = scl_s & ~prev_q[1];
   assign scl_fall  = ~scl_s & prev_q[1];
   assign start_det = scl_s & prev_q[1] & prev_q[0] & ~sda_s;
   assign stop_det  = scl_s & prev_q[1] & ~prev_q[0] & sda_s;
endmodule

// File: rtl/tw_byte_shift.sv
module tw_byte_shift #(
   parameter int W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic                   take,
   input  logic                   din,
   output logic [W-1:0]           data,
   output logic [$clog2(W+1)-1:0] cnt
);
   localparam int CW = $clog2(W + 1);

   generate
      if (W < 2) begin : g_bad_width
         $error("tw_byte_shift: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '0;
         cnt  <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (take) begin
         data <= {data[W-2:0], din};
         if (cnt != CW'(W)) cnt <= cnt + 1'b1;
      end
   end

   a_r7_count_clears: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> cnt == '0);
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
   import tw_pkg::*;
#(
   parameter int         ADDR_W      = 15,
   parameter int         STRAP_W     = 3,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] TYPE_CODE   = 4'b1010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_pull_o,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               wp_i,
   input  logic               busy_i,
   output logic               ptr_load_o,
   output logic [ADDR_W-1:0]  ptr_load_val_o,
   output logic               ptr_step_o,
   output logic               ptr_step_page_o,
   output logic               wr_req_o,
   output logic [BYTE_W-1:0]  wr_byte_o,
   input  logic               wr_gnt_i,
   output logic               rd_req_o,
   input  logic               rd_gnt_i,
   input  logic [BYTE_W-1:0]  rd_data_i,
   output logic               prog_req_o
);
   localparam int HI_W = ADDR_W - BYTE_W;
   localparam int CW   = $clog2(BYTE_W + 1);

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("tw_eeprom_slave: ADDR_W must lie in 9..16");
      end
      if (4 + STRAP_W + 1 != BYTE_W) begin : g_bad_ctrl
         $error("tw_eeprom_slave: control byte layout must fill one byte");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   eng_st_t           st_q;
   fld_t              kind_q;
   logic              rd_q, wrote_q, pull_q, mack_q;
   logic [HI_W-1:0]   hi_q;
   logic [BYTE_W-1:0] tx_q, wr_byte_q, rx_byte;
   logic              rd_pend_q, wr_pend_q;
   logic              ptr_load_q, step_q, step_page_q, prog_q;
   logic [ADDR_W-1:0] ptr_val_q;
   logic [CW-1:0]     cnt;
   logic              shift_clear, shift_take, byte_done, match;

   assign shift_take  = scl_rise && (st_q == ST_RX || st_q == ST_TX);
   assign shift_clear = start_det ||
                        (scl_fall && (cnt == CW'(BYTE_W) || st_q == ST_ACK || st_q == ST_MACK));

   tw_byte_shift #(.W(BYTE_W)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (shift_clear),
      .take  (shift_take),
      .din   (sda_s),
      .data  (rx_byte),
      .cnt   (cnt)
   );

   assign byte_done = scl_fall && st_q == ST_RX && cnt == CW'(BYTE_W);
   assign match     = rx_byte[BYTE_W-1 -: 4] == TYPE_CODE &&
                      rx_byte[STRAP_W:1] == strap_i && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         kind_q      <= K_CTRL;
         rd_q        <= 1'b0;
         wrote_q     <= 1'b0;
         pull_q      <= 1'b0;
         mack_q      <= 1'b0;
         hi_q        <= '0;
         tx_q        <= '0;
         wr_byte_q   <= '0;
         rd_pend_q   <= 1'b0;
         wr_pend_q   <= 1'b0;
         ptr_load_q  <= 1'b0;
         ptr_val_q   <= '0;
         step_q      <= 1'b0;
         step_page_q <= 1'b0;
         prog_q      <= 1'b0;
      end else begin
         ptr_load_q <= 1'b0;
         step_q     <= 1'b0;
         prog_q     <= 1'b0;

         if (rd_pend_q && rd_gnt_i) begin
            tx_q        <= rd_data_i;
            rd_pend_q   <= 1'b0;
            step_q      <= 1'b1;
            step_page_q <= 1'b0;
         end
         if (wr_pend_q && wr_gnt_i) begin
            wr_pend_q   <= 1'b0;
            step_q      <= 1'b1;
            step_page_q <= 1'b1;
         end

         if (start_det) begin
            st_q   <= ST_RX;
            kind_q <= K_CTRL;
            pull_q <= 1'b0;
         end else if (stop_det) begin
            st_q    <= ST_IDLE;
            pull_q  <= 1'b0;
            prog_q  <= wrote_q;
            wrote_q <= 1'b0;
         end else begin
            case (st_q)
               ST_RX: begin
                  if (byte_done) begin
                     case (kind_q)
                        K_CTRL: begin
                           if (match) begin
                              st_q   <= ST_ACK;
                              pull_q <= 1'b1;
                              rd_q   <= rx_byte[0];
                              if (rx_byte[0]) rd_pend_q <= 1'b1;
                           end else begin
                              st_q <= ST_IGNORE;
                           end
                        end
                        K_AHI: begin
                           hi_q   <= rx_byte[HI_W-1:0];
                           st_q   <= ST_ACK;
                           pull_q <= 1'b1;
                        end
                        K_ALO: begin
                           ptr_load_q <= 1'b1;
                           ptr_val_q  <= {hi_q, rx_byte};
                           st_q       <= ST_ACK;
                           pull_q     <= 1'b1;
                        end
                        default: begin
                           if (wp_i) begin
                              st_q <= ST_IGNORE;
                           end else begin
                              wr_pend_q <= 1'b1;
                              wr_byte_q <= rx_byte;
                              wrote_q   <= 1'b1;
                              st_q      <= ST_ACK;
                              pull_q    <= 1'b1;
                           end
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     if (kind_q == K_CTRL && rd_q) begin
                        st_q   <= ST_TX;
                        pull_q <= ~tx_q[BYTE_W-1];
                     end else begin
                        st_q   <= ST_RX;
                        kind_q <= next_fld(kind_q);
                        pull_q <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt == CW'(BYTE_W)) begin
                        st_q   <= ST_MACK;
                        pull_q <= 1'b0;
                     end else begin
                        tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                        pull_q <= ~tx_q[BYTE_W-2];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_s;
                     if (!sda_s) rd_pend_q <= 1'b1;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        st_q   <= ST_TX;
                        pull_q <= ~tx_q[BYTE_W-1];
                     end else begin
                        st_q <= ST_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_pull_o      = pull_q;
   assign ptr_load_o      = ptr_load_q;
   assign ptr_load_val_o  = ptr_val_q;
   assign ptr_step_o      = step_q;
   assign ptr_step_page_o = step_page_q;
   assign wr_req_o        = wr_pend_q;
   assign wr_byte_o       = wr_byte_q;
   assign rd_req_o        = rd_pend_q;
   assign prog_req_o      = prog_q;

   // R11: the line only moves during the clock-low phase
   a_r11_pull_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pull_q) |-> !$past(scl_s));
   a_r1_start_resync: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (st_q == ST_RX && kind_q == K_CTRL && !pull_q));
   a_r6_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && kind_q == K_CTRL && busy_i) |=> (!pull_q && st_q == ST_IGNORE));
   a_r5_wp_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && kind_q == K_DATA && wp_i) |=> (!pull_q && !wr_req_o));
   a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && !wr_gnt_i) |=> wr_req_o);
   a_r7_mack_released: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_MACK) |-> !sda_pull_o);
   a_r10_prog_single: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req_o |=> !prog_req_o);
   a_r3_load_single: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_load_o |=> !ptr_load_o);
endmodule

// File: tb/tw_eeprom_slave_test.sv
module tw_eeprom_slave_test;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 10;
   localparam int BUSY_CYC   = 600;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic [2:0]  strap = 3'b101;
   logic        wp = 1'b0;
   logic        busy;
   logic        sda_pull, ptr_load, ptr_step, ptr_step_page;
   logic [14:0] ptr_val;
   logic        wr_req, rd_req, prog_req;
   logic [7:0]  wr_byte;
   logic        wr_gnt, rd_gnt;
   logic [7:0]  rd_data;
   logic        bus_sda;

   int n_chk = 0;
   int n_err = 0;
   int mon_err = 0;
   int prog_cnt = 0;
   int wr_cnt = 0;
   int busy_cnt;
   bit done = 0;
   logic [14:0] ptr;
   logic [14:0] last_load;
   logic [7:0]  mem   [int];
   logic [7:0]  stage [int];

   assign bus_sda = sda_m & ~sda_pull;
   assign busy    = (busy_cnt > 0);

   always #(CLK_PERIOD / 2) clk = ~clk;

   tw_eeprom_slave uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .scl_i           (scl_m),
      .sda_i           (bus_sda),
      .sda_pull_o      (sda_pull),
      .strap_i         (strap),
      .wp_i            (wp),
      .busy_i          (busy),
      .ptr_load_o      (ptr_load),
      .ptr_load_val_o  (ptr_val),
      .ptr_step_o      (ptr_step),
      .ptr_step_page_o (ptr_step_page),
      .wr_req_o        (wr_req),
      .wr_byte_o       (wr_byte),
      .wr_gnt_i        (wr_gnt),
      .rd_req_o        (rd_req),
      .rd_gnt_i        (rd_gnt),
      .rd_data_i       (rd_data),
      .prog_req_o      (prog_req)
   );

   function automatic logic [7:0] init_val(input int a);
      return 8'((a * 37) + 11);
   endfunction

   function automatic logic [7:0] mem_rd(input int a);
      if (mem.exists(a)) return mem[a];
      return init_val(a);
   endfunction

   // environment: address counter, page buffer, array and program timer
   always @(posedge clk) begin
      if (!rst_n) begin
         wr_gnt    <= 1'b0;
         rd_gnt    <= 1'b0;
         rd_data   <= 8'h00;
         ptr       <= '0;
         last_load <= '0;
         busy_cnt  <= 0;
      end else begin
         wr_gnt <= wr_req & ~wr_gnt;
         rd_gnt <= rd_req & ~rd_gnt;
         if (rd_req & ~rd_gnt) rd_data <= mem_rd(int'(ptr));
         if (wr_req & wr_gnt) begin
            stage[int'(ptr)] = wr_byte;
            wr_cnt++;
         end
         if (ptr_load) begin
            ptr       <= ptr_val;
            last_load <= ptr_val;
         end else if (ptr_step) begin
            if (ptr_step_page) ptr <= {ptr[14:6], ptr[5:0] + 6'd1};
            else ptr <= ptr + 15'd1;
         end
         if (prog_req) begin
            foreach (stage[k]) mem[k] = stage[k];
            stage.delete();
            prog_cnt++;
            busy_cnt <= BUSY_CYC;
         end else if (busy_cnt > 0) begin
            busy_cnt <= busy_cnt - 1;
         end
      end
   end

   // per-clock monitor (R11): pull enable must hold while SCL stays high
   logic prev_pull = 1'b0;
   logic prev_scl  = 1'b1;
   always @(negedge clk) begin
      if (rst_n && sda_pull != prev_pull && scl_m && prev_scl) begin
         mon_err++;
         $display("FAIL R11: pull changed in SCL high, actual=%0b expected=%0b", sda_pull, prev_pull);
      end
      prev_pull = sda_pull;
      prev_scl  = scl_m;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic qtr();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; qtr();
      scl_m = 1'b1; qtr();
      sda_m = 1'b0; qtr();
      scl_m = 1'b0; qtr();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; qtr();
      scl_m = 1'b1; qtr();
      sda_m = 1'b1; qtr();
      qtr();
   endtask

   task automatic clk_bit(input logic b, output logic s);
      sda_m = b; qtr();
      scl_m = 1'b1; qtr();
      s = bus_sda; qtr();
      scl_m = 1'b0; qtr();
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
      clk_bit(1'b1, s);
      acked = ~s;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         v[i] = s;
      end
      clk_bit(~give_ack, s);
   endtask

   function automatic logic [7:0] ctl(input logic [2:0] dev, input logic rw);
      return {4'b1010, dev, rw};
   endfunction

   task automatic addr_phase(input logic [7:0] hi, input logic [7:0] lo, input string tag);
      logic a;
      bus_start();
      send_byte(ctl(3'b101, 1'b0), a);
      chk(a, tag, a, 1);
      send_byte(hi, a);
      chk(a, tag, a, 1);
      send_byte(lo, a);
      chk(a, tag, a, 1);
   endtask

   task automatic rand_read1(input logic [7:0] hi, input logic [7:0] lo,
                             input logic [7:0] exp, input string tag);
      logic a;
      logic [7:0] v;
      addr_phase(hi, lo, tag);
      bus_start();
      send_byte(ctl(3'b101, 1'b1), a);
      chk(a, tag, a, 1);
      recv_byte(1'b0, v);
      chk(v == exp, tag, v, exp);
      bus_stop();
   endtask

   task automatic wait_ready(output int nacks);
      logic a;
      nacks = 0;
      for (int t = 0; t < 20; t++) begin
         bus_start();
         send_byte(ctl(3'b101, 1'b0), a);
         bus_stop();
         if (a) break;
         nacks++;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic a;
      logic [7:0] v;
      int nk, pc, wc;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!sda_pull && !wr_req && !rd_req && !prog_req && !ptr_load, "R11 reset",
          {sda_pull, wr_req, rd_req, prog_req}, 0);

      // R2 wrong strap and wrong type code
      bus_start();
      send_byte(ctl(3'b100, 1'b0), a);
      chk(!a, "R2 strap mismatch", a, 0);
      bus_stop();
      bus_start();
      send_byte(8'b1011_1010, a);
      chk(!a, "R2 type mismatch", a, 0);
      send_byte(8'h00, a);
      chk(!a, "R2 stays released", a, 0);
      bus_stop();

      // R3/R4/R10 byte write, high bit of address ignored
      pc = prog_cnt;
      addr_phase(8'h81, 8'h23, "R3 address ack");
      chk(last_load == 15'h0123, "R3 load value", last_load, 15'h0123);
      send_byte(8'h5A, a);
      chk(a, "R4 data ack", a, 1);
      bus_stop();
      chk(prog_cnt == pc + 1, "R10 program once", prog_cnt, pc + 1);

      // R6 busy polling
      wait_ready(nk);
      chk(nk >= 1, "R6 nack while busy", nk, 1);
      chk(prog_cnt == pc + 1, "R10 no program on poll", prog_cnt, pc + 1);

      // R8 random read, then R7 released after master nack
      addr_phase(8'h01, 8'h23, "R8 address");
      bus_start();
      send_byte(ctl(3'b101, 1'b1), a);
      chk(a, "R8 read ctrl ack", a, 1);
      recv_byte(1'b0, v);
      chk(v == 8'h5A, "R8 data", v, 8'h5A);
      recv_byte(1'b0, v);
      chk(v == 8'hFF, "R7 released after nack", v, 8'hFF);
      bus_stop();

      // R4 page write wrapping within the page
      pc = prog_cnt;
      addr_phase(8'h01, 8'h3E, "R4 page address");
      send_byte(8'h11, a); chk(a, "R4 page byte0", a, 1);
      send_byte(8'h22, a); chk(a, "R4 page byte1", a, 1);
      send_byte(8'h33, a); chk(a, "R4 page byte2", a, 1);
      bus_stop();
      chk(prog_cnt == pc + 1, "R10 page program", prog_cnt, pc + 1);
      wait_ready(nk);
      rand_read1(8'h01, 8'h00, 8'h33, "R4 wrap to page start");

      // R9 current-address read continues after last read
      bus_start();
      send_byte(ctl(3'b101, 1'b1), a);
      chk(a, "R9 ctrl ack", a, 1);
      recv_byte(1'b0, v);
      chk(v == init_val(16'h0101), "R9 current address", v, init_val(16'h0101));
      bus_stop();

      // R7 sequential read crossing the page boundary
      addr_phase(8'h01, 8'h3E, "R7 address");
      bus_start();
      send_byte(ctl(3'b101, 1'b1), a);
      recv_byte(1'b1, v);
      chk(v == 8'h11, "R7 seq byte0", v, 8'h11);
      recv_byte(1'b1, v);
      chk(v == 8'h22, "R7 seq byte1", v, 8'h22);
      recv_byte(1'b0, v);
      chk(v == init_val(16'h0140), "R7 seq byte2", v, init_val(16'h0140));
      bus_stop();

      // R5 write protect
      wp = 1'b1;
      pc = prog_cnt;
      wc = wr_cnt;
      addr_phase(8'h02, 8'h00, "R5 address ack under protect");
      send_byte(8'h77, a);
      chk(!a, "R5 data refused", a, 0);
      bus_stop();
      repeat (20) @(negedge clk);
      chk(prog_cnt == pc, "R5 no program", prog_cnt, pc);
      chk(wr_cnt == wc, "R5 no buffer write", wr_cnt, wc);
      wp = 1'b0;
      rand_read1(8'h02, 8'h00, init_val(16'h0200), "R5 content unchanged");

      // R1 START in the middle of the low address byte
      bus_start();
      send_byte(ctl(3'b101, 1'b0), a);
      send_byte(8'h03, a);
      clk_bit(1'b1, a); clk_bit(1'b0, a); clk_bit(1'b1, a);
      bus_start();
      send_byte(ctl(3'b101, 1'b1), a);
      chk(a, "R1 restart ctrl ack", a, 1);
      recv_byte(1'b0, v);
      chk(v == init_val(16'h0201), "R1 no address load", v, init_val(16'h0201));
      bus_stop();

      // R10 stop after address only: loads, no program
      pc = prog_cnt;
      addr_phase(8'h03, 8'h00, "R10 address only");
      bus_stop();
      repeat (20) @(negedge clk);
      chk(prog_cnt == pc, "R10 no program after address", prog_cnt, pc);
      bus_start();
      send_byte(ctl(3'b101, 1'b1), a);
      recv_byte(1'b0, v);
      chk(v == init_val(16'h0300), "R10 dummy write address used", v, init_val(16'h0300));
      bus_stop();

      // R2 strap change
      strap = 3'b010;
      bus_start();
      send_byte(ctl(3'b101, 1'b0), a);
      chk(!a, "R2 old strap refused", a, 0);
      bus_stop();
      bus_start();
      send_byte(ctl(3'b010, 1'b0), a);
      chk(a, "R2 new strap ack", a, 1);
      bus_stop();
      strap = 3'b101;

      chk(mon_err == 0, "R11 monitor", mon_err, 0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule